// File: doc/BRIEF.md
# Chained-Handshake Kernel Control Register Slave

This block is the host-facing register slave of a cipher kernel. A host reaches it through a simple register read/write port. Writes are taken in the cycle they are presented and acknowledged one cycle later. Reads return their data one cycle after the request. The block holds the kernel's job arguments and drives them straight to the datapath:

- cipher direction
- chaining select
- a 128-bit initial vector
- a block count
- 64-bit source and destination buffer addresses

The control word at offset 0x000 carries a split start/done handshake. On the input side, a start request written by the host stays pending until the datapath reports ready. The edge where start and ready are both high launches the job and clears start. On the output side, a completion reported by the datapath stays latched until the host writes the continue bit. Continue is a one-cycle pulse, and the datapath also sees it. Because the two sides are independent, a new job can be accepted while the previous job's completion is still unacknowledged, so jobs overlap.

The control word holds read-only views of idle and ready. Offsets that are not mapped read as zero and ignore writes. The block has no interrupt output.

Top module: `kctl_regs`

## Requirements
- R1: After reset, every argument register, the start flag, the done flag and the continue pulse are 0, and `rd_valid` and `wr_ack` are low.
- R2: A write to an argument offset stores each byte whose strobe bit is set and keeps the other bytes. The offsets are: direction 0x010, IV words 3/2/1/0 at 0x018/0x020/0x028/0x030, block count 0x038, source low/high 0x040/0x044, destination low/high 0x048/0x04C, chaining 0x050. Direction and chaining keep only bit 0, and their upper bits read 0. `iv` is {word3, word2, word1, word0}, with word3 in the top 32 bits. `src_addr` and `dst_addr` are {high, low}.
- R3: Writing 1 to control bit 0, with byte strobe 0 set, makes `job_start` high from the next cycle. It then stays high while `job_ready` is low, and writing 0 to bit 0 does not clear it. At the first edge where `job_ready` is high, it clears.
- R4: Control word layout on read: bit 0 start, bit 1 done, bit 2 idle, bit 3 ready, bit 4 continue, bits 31:5 zero.
- R5: A `job_done` pulse sets the done flag. The flag stays set until an edge where the host writes 1 to control bit 4. If `job_done` and that write happen in the same cycle, the flag stays set.
- R6: A write of 1 to control bit 4 makes `job_continue` high for exactly the next cycle. Control bit 4 reads 1 only during that cycle.
- R7: While a done flag is pending, a new start can be written and launched by `job_ready` without disturbing the done flag.
- R8: Control bit 2 reads 1 exactly when `job_idle` is high and no done flag is pending.
- R9: Control bit 3 reads the current level of `job_ready`.
- R10: Unmapped offsets (for example 0x014 and 0x100) read as 0, and writes to them change no register.
- R11: `rd_valid` is high exactly in the cycle after `rd_en`, and `wr_ack` exactly in the cycle after `wr_en`.
- R12: Writes to control bits 1, 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request, taken this cycle |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte write enables |
| wr_ack | output | 1 | Write acknowledge, one cycle after `wr_en` |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read byte offset |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| job_start | output | 1 | Pending start request to the datapath |
| job_ready | input | 1 | Datapath can accept a job |
| job_done | input | 1 | Datapath completion pulse |
| job_idle | input | 1 | Datapath has no job in flight |
| job_continue | output | 1 | One-cycle completion acknowledge |
| cipher_enc | output | 1 | 1 = encrypt, 0 = decrypt |
| chain_en | output | 1 | 1 = chained blocks, 0 = independent blocks |
| iv | output | 128 | Initial vector |
| word_count | output | 32 | Number of 128-bit blocks |
| src_addr | output | 64 | Source buffer address |
| dst_addr | output | 64 | Destination buffer address |

## Verification
The hardest situations to reach are the overlap cases: a start that launches while a completion is still unacknowledged, and a completion that arrives in the same cycle as the host's continue write. The bench first leaves a done flag pending. It then writes start and pulses ready, and checks that done survives. It also lines up a `job_done` pulse and a continue write on the same negative edge, so both are sampled at one clock edge. The one-cycle continue pulse is caught by issuing a control read in the cycle right after the continue write.

// File: rtl/kctl_pkg.sv
// Package: shared widths, argument slot map and address decode helpers for
// the kernel control register slave. Assumes a 32-bit word-aligned map.
package kctl_pkg;

    localparam int CSR_AW   = 12;
    localparam int CSR_DW   = 32;
    localparam int CSR_BYTES = CSR_DW / 8;
    localparam int NSLOT    = 11;

    localparam int SL_DIR   = 0;
    localparam int SL_IV3   = 1;
    localparam int SL_IV2   = 2;
    localparam int SL_IV1   = 3;
    localparam int SL_IV0   = 4;
    localparam int SL_CNT   = 5;
    localparam int SL_SRCL  = 6;
    localparam int SL_SRCH  = 7;
    localparam int SL_DSTL  = 8;
    localparam int SL_DSTH  = 9;
    localparam int SL_CHAIN = 10;

    localparam logic [CSR_AW-1:0] CTRL_OFF = '0;

    // Byte offset of each argument slot
    function automatic logic [CSR_AW-1:0] slot_off(input int s);
        case (s)
            SL_DIR:   return 12'h010;
            SL_IV3:   return 12'h018;
            SL_IV2:   return 12'h020;
            SL_IV1:   return 12'h028;
            SL_IV0:   return 12'h030;
            SL_CNT:   return 12'h038;
            SL_SRCL:  return 12'h040;
            SL_SRCH:  return 12'h044;
            SL_DSTL:  return 12'h048;
            SL_DSTH:  return 12'h04C;
            SL_CHAIN: return 12'h050;
            default:  return 12'hFFC;
        endcase
    endfunction

    // Bits kept by each slot: single-bit selects keep bit 0 only
    function automatic logic [CSR_DW-1:0] slot_mask(input int s);
        if (s == SL_DIR || s == SL_CHAIN)
            return {{(CSR_DW-1){1'b0}}, 1'b1};
        return '1;
    endfunction

    // Word-level address match, ignoring the byte lane bits
    function automatic logic same_word(input logic [CSR_AW-1:0] a,
                                       input logic [CSR_AW-1:0] b);
        return (a >> 2) == (b >> 2);
    endfunction

    function automatic logic hits_ctrl(input logic [CSR_AW-1:0] a);
        return same_word(a, CTRL_OFF);
    endfunction

    function automatic logic is_mapped(input logic [CSR_AW-1:0] a);
        logic m;
        m = hits_ctrl(a);
        for (int s = 0; s < NSLOT; s++)
            if (same_word(a, slot_off(s))) m = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/kctl_argfile.sv
// Argument register file: one register per slot, byte-strobed writes,
// unused bits of narrow slots held at zero. Assumes writes are accepted
// in the cycle wr_en is high.
module kctl_argfile
    import kctl_pkg::*;
#(
    parameter int AW = CSR_AW,
    parameter int DW = CSR_DW,
    parameter int NS = NSLOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [DW/8-1:0]   wr_strb,
    output logic [DW-1:0]     slot_q [NS]
);
    localparam int NB = DW / 8;

    for (genvar s = 0; s < NS; s++) begin : g_slot
        localparam logic [DW-1:0] MASK = slot_mask(s);
        localparam logic [AW-1:0] OFF  = slot_off(s);
        logic [DW-1:0] q;
        logic          sel;

        assign sel = wr_en && same_word(wr_addr, OFF);

        // Byte-lane update of this slot under the write strobes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (sel) begin
                for (int b = 0; b < NB; b++)
                    if (wr_strb[b])
                        q[b*8 +: 8] <= wr_data[b*8 +: 8] & MASK[b*8 +: 8];
            end
        end

        assign slot_q[s] = q;
    end

endmodule

// File: rtl/kctl_sync.sv
// Start/done handshake: start waits for ready, done waits for the host
// continue write, continue is a single-cycle pulse. Assumes job_done is a
// pulse from the datapath and set_start / hit_cont are decoded writes.
module kctl_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic set_start,
    input  logic hit_cont,
    input  logic ready_i,
    input  logic done_i,
    input  logic idle_i,
    output logic start_q,
    output logic done_q,
    output logic cont_q,
    output logic idle_o
);
    // Input sync: host sets, the launch edge (start & ready) clears
    always_ff @(posedge clk) begin
        if (!rst_n)                 start_q <= 1'b0;
        else if (set_start)         start_q <= 1'b1;
        else if (start_q && ready_i) start_q <= 1'b0;
    end

    // Output sync: completion latches, the continue write clears
    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (done_i)   done_q <= 1'b1;
        else if (hit_cont) done_q <= 1'b0;
    end

    // Self-clearing acknowledge pulse
    always_ff @(posedge clk) begin
        if (!rst_n) cont_q <= 1'b0;
        else        cont_q <= hit_cont;
    end

    assign idle_o = idle_i && !done_q;

endmodule

// File: rtl/kctl_rdport.sv
// Registered read port: selects control word or an argument slot, returns
// zero for unmapped offsets, data and valid one cycle after the request.
module kctl_rdport
    import kctl_pkg::*;
#(
    parameter int AW = CSR_AW,
    parameter int DW = CSR_DW,
    parameter int NS = NSLOT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] ctrl_word,
    input  logic [DW-1:0] slot_q [NS],
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] sel_val;

    // Address decode into the read value
    always_comb begin
        sel_val = '0;
        if (hits_ctrl(rd_addr)) sel_val = ctrl_word;
        for (int s = 0; s < NS; s++)
            if (same_word(rd_addr, slot_off(s))) sel_val = slot_q[s];
    end

    // Read response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? sel_val : '0;
        end
    end

endmodule

// File: rtl/kctl_regs.sv
// Top: kernel control register slave. Decodes the control word writes,
// instantiates argument file, handshake and read port, and fans the
// arguments out to the datapath. Assumes one write and one read port that
// are always ready.
module kctl_regs
    import kctl_pkg::*;
#(
    parameter int AW = CSR_AW,
    parameter int DW = CSR_DW,
    parameter int NS = NSLOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [DW/8-1:0]   wr_strb,
    output logic              wr_ack,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              job_start,
    input  logic              job_ready,
    input  logic              job_done,
    input  logic              job_idle,
    output logic              job_continue,
    output logic              cipher_enc,
    output logic              chain_en,
    output logic [4*DW-1:0]   iv,
    output logic [DW-1:0]     word_count,
    output logic [2*DW-1:0]   src_addr,
    output logic [2*DW-1:0]   dst_addr
);
    localparam int B_START = 0;
    localparam int B_CONT  = 4;

    logic [DW-1:0] slot_q [NS];
    logic          ctrl_wr, set_start, hit_cont;
    logic          done_flag, idle_bit;
    logic [DW-1:0] ctrl_word;
    logic          unused_hi;

    assign ctrl_wr   = wr_en && hits_ctrl(wr_addr) && wr_strb[0];
    assign set_start = ctrl_wr && wr_data[B_START];
    assign hit_cont  = ctrl_wr && wr_data[B_CONT];

    kctl_argfile #(.AW(AW), .DW(DW), .NS(NS)) u_args (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_strb (wr_strb),
        .slot_q  (slot_q)
    );

    kctl_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_start (set_start),
        .hit_cont  (hit_cont),
        .ready_i   (job_ready),
        .done_i    (job_done),
        .idle_i    (job_idle),
        .start_q   (job_start),
        .done_q    (done_flag),
        .cont_q    (job_continue),
        .idle_o    (idle_bit)
    );

    assign ctrl_word = {{(DW-5){1'b0}}, job_continue, job_ready,
                        idle_bit, done_flag, job_start};

    kctl_rdport #(.AW(AW), .DW(DW), .NS(NS)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .ctrl_word (ctrl_word),
        .slot_q    (slot_q),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // Write acknowledge, one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) wr_ack <= 1'b0;
        else        wr_ack <= wr_en;
    end

    assign cipher_enc = slot_q[SL_DIR][0];
    assign chain_en   = slot_q[SL_CHAIN][0];
    assign iv         = {slot_q[SL_IV3], slot_q[SL_IV2], slot_q[SL_IV1], slot_q[SL_IV0]};
    assign word_count = slot_q[SL_CNT];
    assign src_addr   = {slot_q[SL_SRCH], slot_q[SL_SRCL]};
    assign dst_addr   = {slot_q[SL_DSTH], slot_q[SL_DSTL]};
    assign unused_hi  = ^{slot_q[SL_DIR][DW-1:1], slot_q[SL_CHAIN][DW-1:1]};

endmodule

// File: rtl/kctl_regs_chk.sv
// Checker for kctl_regs: handshake and port timing properties, bound to
// every instance of the top module.
module kctl_regs_chk
    import kctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CSR_AW-1:0] wr_addr,
    input logic [CSR_DW-1:0] wr_data,
    input logic [3:0]        wr_strb,
    input logic              wr_ack,
    input logic              rd_en,
    input logic [CSR_AW-1:0] rd_addr,
    input logic              rd_valid,
    input logic [CSR_DW-1:0] rd_data,
    input logic              job_start,
    input logic              job_ready,
    input logic              job_done,
    input logic              job_continue,
    input logic              done_flag
);
    logic cw, swr, cwr;
    assign cw  = wr_en && hits_ctrl(wr_addr) && wr_strb[0];
    assign swr = cw && wr_data[0];
    assign cwr = cw && wr_data[4];

    p_start_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> job_start);
    p_start_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        job_start && !job_ready |=> job_start);
    p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        job_start && job_ready && !swr |=> !job_start);
    p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |=> done_flag);
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag && !cwr |=> done_flag);
    p_cont_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cwr |=> job_continue);
    p_cont_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cwr |=> !job_continue);
    p_launch_keeps_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        job_start && job_ready && done_flag && !job_done && !cwr |=> done_flag && !job_start);
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !is_mapped(rd_addr) |=> rd_data == '0);
    p_rd_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_rd_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    p_wack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wr_ack);

endmodule

bind kctl_regs kctl_regs_chk u_chk (.*);

// File: tb/kctl_regs_test.sv
`timescale 1ns/1ps
module kctl_regs_test;
    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [31:0] expv;
    } vec_t;

    // R2 / R10 register vectors: write then read back
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{12'h010, 32'hFFFF_FFFF, 4'hF, 32'h0000_0001},
        '{12'h018, 32'h1122_3344, 4'hF, 32'h1122_3344},
        '{12'h020, 32'h5566_7788, 4'hF, 32'h5566_7788},
        '{12'h028, 32'h99AA_BBCC, 4'hF, 32'h99AA_BBCC},
        '{12'h030, 32'hDDEE_FF00, 4'hF, 32'hDDEE_FF00},
        '{12'h038, 32'h0000_0100, 4'hF, 32'h0000_0100},
        '{12'h040, 32'hA000_0000, 4'hF, 32'hA000_0000},
        '{12'h044, 32'h0000_0001, 4'hF, 32'h0000_0001},
        '{12'h048, 32'hB000_0000, 4'hF, 32'hB000_0000},
        '{12'h04C, 32'h0000_0002, 4'hF, 32'h0000_0002},
        '{12'h050, 32'hFFFF_FFFE, 4'hF, 32'h0000_0000},
        '{12'h050, 32'h0000_0003, 4'hF, 32'h0000_0001},
        '{12'h038, 32'hFFFF_FFFF, 4'h5, 32'h00FF_01FF},
        '{12'h040, 32'h1234_5678, 4'h0, 32'hA000_0000},
        '{12'h014, 32'hDEAD_BEEF, 4'hF, 32'h0000_0000},
        '{12'h100, 32'hDEAD_BEEF, 4'hF, 32'h0000_0000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   wr_strb = '0;
    logic         wr_ack, rd_valid;
    logic [31:0]  rd_data;
    logic         job_start, job_continue, cipher_enc, chain_en;
    logic         job_ready = 1'b0, job_done = 1'b0, job_idle = 1'b1;
    logic [127:0] iv;
    logic [31:0]  word_count;
    logic [63:0]  src_addr, dst_addr;

    int nchk = 0;
    int nbad = 0;
    logic [31:0] rv;
    logic        rvld;

    always #2 clk = ~clk;

    kctl_regs uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .wr_ack(wr_ack),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .job_start(job_start), .job_ready(job_ready), .job_done(job_done),
        .job_idle(job_idle), .job_continue(job_continue),
        .cipher_enc(cipher_enc), .chain_en(chain_en), .iv(iv),
        .word_count(word_count), .src_addr(src_addr), .dst_addr(dst_addr)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rv = rd_data; rvld = rd_valid;
        rd_en = 1'b0;
    endtask

    task automatic pulse_ready();
        @(negedge clk); job_ready = 1'b1;
        @(negedge clk); job_ready = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); job_done = 1'b1;
        @(negedge clk); job_done = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        nchk++; nbad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 job_start", job_start, 0);
        chk("R1 job_continue", job_continue, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 wr_ack", wr_ack, 0);
        rst_n = 1'b1;
        rd(12'h038); chk("R1 count reg", rv, 0);
        chk("R1 iv out", iv, 0);
        rd(12'h000); chk("R1 ctrl word", rv, 32'h4);

        // Vector table walk (R2 storage, R10 unmapped)
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].addr, VEC[i].data, VEC[i].strb);
            rd(VEC[i].addr);
            chk($sformatf("R2/R10 vector %0d", i), rv, VEC[i].expv);
        end
        chk("R2 iv out", iv, 128'h11223344_55667788_99AABBCC_DDEEFF00);
        chk("R2 word_count", word_count, 32'h00FF01FF);
        chk("R2 src_addr", src_addr, 64'h00000001_A0000000);
        chk("R2 dst_addr", dst_addr, 64'h00000002_B0000000);
        chk("R2 cipher_enc", cipher_enc, 1);
        chk("R2 chain_en", chain_en, 1);
        // R10 neighbours untouched by the unmapped writes
        rd(12'h010); chk("R10 dir intact", rv, 1);
        rd(12'h018); chk("R10 iv3 intact", rv, 32'h11223344);

        // R11 response timing
        @(negedge clk); wr_en = 1'b1; wr_addr = 12'h038; wr_data = 32'h00FF01FF; wr_strb = 4'hF;
        @(negedge clk); wr_en = 1'b0; wr_strb = '0;
        chk("R11 wr_ack after write", wr_ack, 1);
        @(negedge clk); chk("R11 wr_ack drops", wr_ack, 0);
        rd(12'h000); chk("R11 rd_valid", rvld, 1);
        @(negedge clk); chk("R11 rd_valid drops", rd_valid, 0);

        // R12 read-only control bits, R4 layout
        wr(12'h000, 32'h0000_000E, 4'hF);
        rd(12'h000); chk("R12 ro bits ignored", rv, 32'h4);
        // R9 ready view
        @(negedge clk); job_ready = 1'b1;
        rd(12'h000); chk("R9 ready bit", rv, 32'hC);
        job_ready = 1'b0;

        // R3 start holds until ready
        wr(12'h000, 32'h1, 4'h1);
        chk("R3 start set", job_start, 1);
        repeat (3) @(negedge clk);
        wr(12'h000, 32'h0, 4'h1);
        chk("R3 start holds without ready", job_start, 1);
        rd(12'h000); chk("R4 ctrl with start", rv, 32'h5);
        pulse_ready();
        chk("R3 start cleared by ready", job_start, 0);
        rd(12'h000); chk("R4 ctrl after launch", rv, 32'h4);

        // R5 done latches until continue
        pulse_done();
        rd(12'h000); chk("R5 done set, R8 idle low", rv, 32'h2);
        repeat (4) @(negedge clk);
        wr(12'h000, 32'h0, 4'h1);
        rd(12'h000); chk("R5 done held", rv, 32'h2);

        // R7 overlap: new job accepted while done pending
        wr(12'h000, 32'h1, 4'h1);
        rd(12'h000); chk("R7 start with done", rv, 32'h3);
        pulse_ready();
        chk("R7 launched", job_start, 0);
        rd(12'h000); chk("R7 done survives launch", rv, 32'h2);

        // R6 continue pulse, read in the pulse cycle
        @(negedge clk); wr_en = 1'b1; wr_addr = 12'h000; wr_data = 32'h10; wr_strb = 4'h1;
        @(negedge clk); wr_en = 1'b0; wr_strb = '0; rd_en = 1'b1; rd_addr = 12'h000;
        chk("R6 continue high", job_continue, 1);
        @(negedge clk); rd_en = 1'b0;
        chk("R6 continue one cycle", job_continue, 0);
        chk("R6 ctrl shows continue, done cleared", rd_data, 32'h14);
        rd(12'h000); chk("R6 continue bit gone", rv, 32'h4);

        // R5 corner: done and continue in the same cycle
        pulse_done();
        @(negedge clk); wr_en = 1'b1; wr_addr = 12'h000; wr_data = 32'h10; wr_strb = 4'h1;
        job_done = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_strb = '0; job_done = 1'b0;
        rd(12'h000); chk("R5 same-cycle done wins", rv, 32'h2);
        wr(12'h000, 32'h10, 4'h1);
        rd(12'h000); chk("R5 cleared after continue", rv, 32'h4);

        // R8 idle follows datapath
        @(negedge clk); job_idle = 1'b0;
        rd(12'h000); chk("R8 busy datapath", rv, 32'h0);
        job_idle = 1'b1;
        rd(12'h000); chk("R8 idle again", rv, 32'h4);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule